// File: doc/BRIEF.md
# Power-Up Configuration Loader with Serial EEPROM

This block sets up a chip's configuration when power comes up. While the external reset is high, it samples the four pins that connect to a serial EEPROM. Outside of loading, resistors on those pins give fixed levels, and these levels become the strap defaults. After reset is released, the block waits until the clock has settled. It then reads 16-bit words from a three-wire serial EEPROM, starting at address 0, using a read frame with a 6-bit address. The block holds the rest of the chip in reset until loading ends.

Word 0 is a signature. If it differs from 0x55AA, loading stops and the strap defaults stay in place. If it matches, every configured word is read in ascending order and replaces its default. Once loading ends, the block stops driving all three output pins, so the EEPROM is isolated and the pins act as plain inputs again. The configuration words can be read through a synchronous read port. A one-cycle done pulse marks the end of loading.

Top module: `serial_cfg_loader`

## Requirements
- R1: The levels on `pins_in[3:0]` are captured on the last clock edge at which `rst` is high. Bit 0 is the select pin, bit 1 the clock pin, bit 2 the data-to-EEPROM pin and bit 3 the data-from-EEPROM pin. Until the EEPROM replaces it, word `STRAP_WORD` (default 1) reads as the captured nibble zero-extended to 16 bits, and every other word reads 0. Pin changes after reset release do not alter this value.
- R2: `chip_rst_o` is high while `rst` is high, and stays high from reset release until the cycle in which loading ends.
- R3: `pins_oe` stays all zero during reset and for at least `WAIT_CYC` clock cycles after reset release.
- R4: In each read frame, the select line rises while the serial clock is low. The data-to-EEPROM line then carries 1, 1, 0 followed by address bits A5 down to A0, each bit stable at its serial-clock rising edge. The serial clock is high only while select is high.
- R5: Each frame has 24 serial-clock periods. The data-from-EEPROM line is sampled at serial-clock falling edges: D15 at the falling edge that ends the 9th period, and D0 at the one that ends the 24th period.
- R6: The serial clock high and low phases each last exactly `HALF_DIV` clock cycles.
- R7: Frames address words 0, 1, 2 and so on in ascending order. Select stays low for at least one full serial-clock period between frames.
- R8: If word 0 is not 0x55AA, no further frame is issued and every word keeps its R1 default.
- R9: If word 0 is 0x55AA, all `NUM_WORDS` words are read. Every word, including word 0 and the strap word, then reads the EEPROM content.
- R10: `done_o` is a single-cycle pulse. It is issued in the same cycle in which `chip_rst_o` falls, whether loading ended on a signature mismatch or after the last word.
- R11: After loading ends, `pins_oe` and `pins_out` stay zero until the next reset.
- R12: `cfg_rdata` shows the word at `cfg_addr` one clock cycle after the address is presented. Addresses at or above `NUM_WORDS` read as 0.
- R13: A reset during loading stops the frame at once, releases the pins on the next edge, and discards the words already loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| pins_in | input | 4 | Levels on the shared pins: select, serial clock, data-to-EEPROM, data-from-EEPROM |
| pins_out | output | 3 | Driven values for select, serial clock and data-to-EEPROM |
| pins_oe | output | 3 | Output enables for the three driven pins |
| chip_rst_o | output | 1 | Reset to the rest of the chip, held until loading ends |
| done_o | output | 1 | One-cycle pulse at the end of loading |
| cfg_addr | input | IDX_W | Configuration word read address |
| cfg_rdata | output | 16 | Configuration word, one cycle after the address |

## Verification
Two events can land on the same clock edge: the last word of a frame is written into the register file, and the load finishes (done pulse, reset release, pins released). The same coincidence occurs when the signature check fails on word 0. The bench provokes the first case with a valid image and the second with corrupted signatures, including a byte-swapped one. It judges the result by reading every word back right after the pulse and expecting either the image or the strap defaults. A second coincidence is a reset that arrives mid-frame. The bench checks that the pins are released on the next edge and that a following failed load shows pure defaults.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W   = 16;
  localparam int EE_AW    = 6;
  localparam int CMD_BITS = 3 + EE_AW;
  localparam int PIN_N    = 4;
  localparam int OUT_N    = 3;
  localparam int PIN_CS   = 0;
  localparam int PIN_SK   = 1;
  localparam int PIN_DI   = 2;
  localparam int PIN_DO   = 3;
  localparam logic [2:0]        RD_OP    = 3'b110;
  localparam logic [WORD_W-1:0] SIG_WORD = 16'h55AA;

  typedef enum logic [1:0] {
    ST_WAIT,
    ST_XFER,
    ST_GAP,
    ST_FIN
  } ld_state_t;
endpackage

// File: rtl/cfgld_strap_cap.sv
module cfgld_strap_cap #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_in,
  output logic [W-1:0] strap_q
);
  // Straps are static resistor levels: sample on every reset cycle, so the
  // value from the final reset edge is what remains.
  always_ff @(posedge clk) begin
    if (rst) strap_q <= pins_in;
  end
endmodule

// File: rtl/cfgld_tick_gen.sv
module cfgld_tick_gen #(
  parameter int HALF_DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq import cfgld_pkg::*; #(
  parameter int NUM_WORDS  = 14,
  parameter int WAIT_CYC   = 1100,
  parameter int GAP_HALVES = 2,
  parameter int IDX_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              do_i,
  output logic              tick_en,
  output logic              cs_q,
  output logic              sk_q,
  output logic              di_q,
  output logic              oe_q,
  output logic              chip_rst_q,
  output logic              done_q,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  localparam int WW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam int GW = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;
  localparam logic [4:0]       FIRST_SMP = 5'(CMD_BITS - 1);
  localparam logic [4:0]       LAST_BIT  = 5'(CMD_BITS + WORD_W - 2);
  localparam logic [EE_AW-1:0] LAST_A    = EE_AW'(NUM_WORDS - 1);

  ld_state_t         st;
  logic [WW-1:0]     wait_cnt;
  logic [GW-1:0]     gap_cnt;
  logic [EE_AW-1:0]  addr;
  logic [4:0]        bcnt;
  logic              ph_hi;
  logic [WORD_W-1:0] shreg;

  logic [CMD_BITS-1:0] cmd;
  logic [CMD_BITS-1:0] cmd_sh;
  logic [4:0]          nxt_b;
  logic                di_nxt;
  logic [WORD_W-1:0]   word_in;

  assign cmd     = {RD_OP, addr};
  assign nxt_b   = bcnt + 5'd1;
  assign cmd_sh  = cmd << nxt_b;
  assign di_nxt  = (nxt_b < 5'(CMD_BITS)) && cmd_sh[CMD_BITS-1];
  assign word_in = {shreg[WORD_W-2:0], do_i};
  assign tick_en = (st == ST_XFER) || (st == ST_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_WAIT;
      wait_cnt   <= '0;
      gap_cnt    <= '0;
      addr       <= '0;
      bcnt       <= '0;
      ph_hi      <= 1'b0;
      shreg      <= '0;
      cs_q       <= 1'b0;
      sk_q       <= 1'b0;
      di_q       <= 1'b0;
      oe_q       <= 1'b0;
      chip_rst_q <= 1'b1;
      done_q     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      done_q <= 1'b0;
      wr_en  <= 1'b0;
      case (st)
        ST_WAIT: begin
          if (wait_cnt == WW'(WAIT_CYC - 1)) begin
            st    <= ST_XFER;
            oe_q  <= 1'b1;
            cs_q  <= 1'b1;
            di_q  <= cmd[CMD_BITS-1];
            bcnt  <= '0;
            ph_hi <= 1'b0;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (!ph_hi) begin
              sk_q  <= 1'b1;
              ph_hi <= 1'b1;
            end else begin
              sk_q  <= 1'b0;
              ph_hi <= 1'b0;
              if (bcnt >= FIRST_SMP) shreg <= word_in;
              if (bcnt == LAST_BIT) begin
                cs_q <= 1'b0;
                di_q <= 1'b0;
                if ((addr == '0) && (word_in != SIG_WORD)) begin
                  st         <= ST_FIN;
                  done_q     <= 1'b1;
                  chip_rst_q <= 1'b0;
                  oe_q       <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= addr[IDX_W-1:0];
                  wr_data <= word_in;
                  if (addr == LAST_A) begin
                    st         <= ST_FIN;
                    done_q     <= 1'b1;
                    chip_rst_q <= 1'b0;
                    oe_q       <= 1'b0;
                  end else begin
                    addr    <= addr + 1'b1;
                    st      <= ST_GAP;
                    gap_cnt <= '0;
                  end
                end
              end else begin
                bcnt <= nxt_b;
                di_q <= di_nxt;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_cnt == GW'(GAP_HALVES - 1)) begin
              st   <= ST_XFER;
              cs_q <= 1'b1;
              di_q <= cmd[CMD_BITS-1];
              bcnt <= '0;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        default: begin
          cs_q <= 1'b0;
          sk_q <= 1'b0;
          di_q <= 1'b0;
          oe_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cfgld_regfile.sv
module cfgld_regfile #(
  parameter int NUM_WORDS  = 14,
  parameter int WORD_W     = 16,
  parameter int STRAP_W    = 4,
  parameter int STRAP_WORD = 1,
  parameter int IDX_W      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]  rd_data
);
  logic [WORD_W-1:0]    mem [NUM_WORDS];
  logic [NUM_WORDS-1:0] loaded;
  logic [WORD_W-1:0]    mem_q;
  logic [WORD_W-1:0]    dflt_q;
  logic                 sel_q;
  logic                 in_rng;

  assign in_rng = int'(rd_addr) < NUM_WORDS;

  // Plain RAM: no reset, one write and one registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  // Valid bits overlay the strap-derived defaults.
  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
      sel_q  <= 1'b0;
      dflt_q <= '0;
    end else begin
      if (wr_en) loaded[wr_addr] <= 1'b1;
      sel_q  <= in_rng && loaded[rd_addr];
      dflt_q <= (in_rng && (int'(rd_addr) == STRAP_WORD)) ?
                {(WORD_W-STRAP_W)'(0), strap} : '0;
    end
  end

  assign rd_data = sel_q ? mem_q : dflt_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader import cfgld_pkg::*; #(
  parameter int NUM_WORDS  = 14,
  parameter int HALF_DIV   = 256,
  parameter int WAIT_CYC   = 1100,
  parameter int GAP_HALVES = 2,
  parameter int STRAP_WORD = 1,
  parameter int IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_N-1:0]  pins_in,
  output logic [OUT_N-1:0]  pins_out,
  output logic [OUT_N-1:0]  pins_oe,
  output logic              chip_rst_o,
  output logic              done_o,
  input  logic [IDX_W-1:0]  cfg_addr,
  output logic [WORD_W-1:0] cfg_rdata
);
  localparam int SYNC_N = 2;

  logic [PIN_N-1:0]  strap;
  logic [SYNC_N-1:0] do_sync;
  logic              tick, tick_en;
  logic              cs_q, sk_q, di_q, oe_q;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_addr;
  logic [WORD_W-1:0] wr_data;

  always_ff @(posedge clk) begin
    if (rst) do_sync <= '0;
    else     do_sync <= {do_sync[SYNC_N-2:0], pins_in[PIN_DO]};
  end

  cfgld_strap_cap #(.W(PIN_N)) strap_i (
    .clk     (clk),
    .rst     (rst),
    .pins_in (pins_in),
    .strap_q (strap)
  );

  cfgld_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk  (clk),
    .rst  (rst),
    .en   (tick_en),
    .tick (tick)
  );

  cfgld_seq #(
    .NUM_WORDS  (NUM_WORDS),
    .WAIT_CYC   (WAIT_CYC),
    .GAP_HALVES (GAP_HALVES),
    .IDX_W      (IDX_W)
  ) seq_i (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .do_i       (do_sync[SYNC_N-1]),
    .tick_en    (tick_en),
    .cs_q       (cs_q),
    .sk_q       (sk_q),
    .di_q       (di_q),
    .oe_q       (oe_q),
    .chip_rst_q (chip_rst_o),
    .done_q     (done_o),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  cfgld_regfile #(
    .NUM_WORDS  (NUM_WORDS),
    .WORD_W     (WORD_W),
    .STRAP_W    (PIN_N),
    .STRAP_WORD (STRAP_WORD),
    .IDX_W      (IDX_W)
  ) rf_i (
    .clk     (clk),
    .rst     (rst),
    .strap   (strap),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (cfg_addr),
    .rd_data (cfg_rdata)
  );

  always_comb begin
    pins_out         = '0;
    pins_out[PIN_CS] = cs_q;
    pins_out[PIN_SK] = sk_q;
    pins_out[PIN_DI] = di_q;
    pins_oe          = {OUT_N{oe_q}};
  end
endmodule

// File: rtl/cfgld_chk.sv
module cfgld_chk import cfgld_pkg::*; #(
  parameter int HALF_DIV = 256,
  parameter int WAIT_CYC = 1100
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_N-1:0] pins_out,
  input logic [OUT_N-1:0] pins_oe,
  input logic             chip_rst_o,
  input logic             done_o
);
  logic [31:0] since_rel;
  logic [31:0] since_edge;

  always_ff @(posedge clk) begin
    if (rst) since_rel <= '0;
    else if (since_rel < 32'(WAIT_CYC)) since_rel <= since_rel + 1;
  end

  always_ff @(posedge clk) begin
    if (rst) since_edge <= '0;
    else if (!$stable(pins_out[PIN_SK]) || !$stable(pins_out[PIN_CS])) since_edge <= '0;
    else since_edge <= since_edge + 1;
  end

  // R2
  rst_hold_chk: assert property (@(posedge clk) rst |=> chip_rst_o);
  // R13
  abort_chk: assert property (@(posedge clk) rst |=> (pins_oe == '0));
  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pins_oe != '0) |-> (since_rel >= 32'(WAIT_CYC)));
  // R4
  cs_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pins_out[PIN_CS]) |-> !pins_out[PIN_SK]);
  // R4
  sk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    pins_out[PIN_SK] |-> pins_out[PIN_CS]);
  // R6
  half_per_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(pins_out[PIN_SK]) |-> (since_edge == 32'(HALF_DIV - 1)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R10
  done_rel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(chip_rst_o) |-> done_o);
  // R11
  idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_rst_o |-> ((pins_oe == '0) && (pins_out == '0)));
endmodule

bind serial_cfg_loader cfgld_chk #(
  .HALF_DIV (HALF_DIV),
  .WAIT_CYC (WAIT_CYC)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .pins_out   (pins_out),
  .pins_oe    (pins_oe),
  .chip_rst_o (chip_rst_o),
  .done_o     (done_o)
);

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int HD  = 3;
  localparam int WC  = 40;
  localparam int NW  = 14;
  localparam int NV  = 5;
  // {expect_loaded, strap nibble, word0 signature, data base}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'hA, 16'h55AA, 16'h1234},
    {1'b0, 4'h5, 16'h55AB, 16'h2222},
    {1'b0, 4'hF, 16'hAA55, 16'h3333},
    {1'b1, 4'h0, 16'h55AA, 16'hFFFF},
    {1'b0, 4'h3, 16'h0000, 16'h5555}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  pins_in;
  logic [2:0]  pins_out, pins_oe;
  logic        chip_rst_o, done_o;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_rdata;

  logic [3:0]  strap_drv;
  logic        ee_do;
  logic        cs_act, sk_act;
  logic [15:0] cur_sig, cur_base, ee_w;
  logic [8:0]  cmd_acc;
  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_rise, cs_fall;
  int bitcnt, dbit, n_frames, frame_err, period_err, gap_err, exp_addr;
  bit have_fall;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign cs_act = pins_oe[0] & pins_out[0];
  assign sk_act = pins_oe[1] & pins_out[1];
  assign pins_in[0] = pins_oe[0] ? pins_out[0] : strap_drv[0];
  assign pins_in[1] = pins_oe[1] ? pins_out[1] : strap_drv[1];
  assign pins_in[2] = pins_oe[2] ? pins_out[2] : strap_drv[2];
  assign pins_in[3] = cs_act ? ee_do : strap_drv[3];

  serial_cfg_loader #(.NUM_WORDS(NW), .HALF_DIV(HD), .WAIT_CYC(WC)) dut_i (
    .clk(clk), .rst(rst), .pins_in(pins_in), .pins_out(pins_out),
    .pins_oe(pins_oe), .chip_rst_o(chip_rst_o), .done_o(done_o),
    .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata));

  function automatic logic [15:0] img_word(int k, logic [15:0] sig, logic [15:0] base);
    return (k == 0) ? sig : 16'(base + 16'(k) * 16'h1357);
  endfunction

  // Behavioural serial EEPROM
  always @(posedge cs_act) begin
    bitcnt = 0;
    if (have_fall && (cyc - cs_fall) < 2 * HD) gap_err++;
  end
  always @(negedge cs_act) begin
    cs_fall = cyc;
    have_fall = 1'b1;
  end
  always @(posedge sk_act) if (cs_act) begin
    if (bitcnt > 0 && (cyc - last_rise) != 2 * HD) period_err++;
    last_rise = cyc;
    bitcnt++;
    if (bitcnt <= 9) cmd_acc = {cmd_acc[7:0], pins_out[2]};
    if (bitcnt == 9) begin
      if (cmd_acc[8:6] != 3'b110 || cmd_acc[5:0] != 6'(exp_addr)) frame_err++;
      ee_w = img_word(int'(cmd_acc[5:0]), cur_sig, cur_base);
      exp_addr++;
      n_frames++;
      dbit = 15;
      ee_do = ee_w[dbit];
    end else if (bitcnt > 9 && bitcnt <= 24) begin
      dbit--;
      ee_do = ee_w[dbit];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reset_model();
    bitcnt = 0; n_frames = 0; frame_err = 0; period_err = 0;
    gap_err = 0; exp_addr = 0; have_fall = 1'b0;
  endtask

  task automatic run_load(input logic [3:0] st, input logic [15:0] sig,
                          input logic [15:0] base, input bit exp_ld);
    int n;
    bit early;
    logic [15:0] e;
    rst = 1'b1; strap_drv = st; cur_sig = sig; cur_base = base;
    repeat (4) @(negedge clk);
    reset_model();
    chk(chip_rst_o == 1'b1, "R2 reset level", 32'(chip_rst_o), 1);
    chk(pins_oe == 3'b000, "R3 pins idle in reset", 32'(pins_oe), 0);
    cfg_addr = 4'd1;
    rst = 1'b0;
    strap_drv = ~st;
    n = 0;
    while (pins_oe == 3'b000 && n < WC + 1000) begin @(negedge clk); n++; end
    chk(n >= WC, "R3 wait before driving", 32'(n), 32'(WC));
    chk(cfg_rdata == {12'h000, st}, "R1 strap word during load", 32'(cfg_rdata), 32'(st));
    early = 1'b0; n = 0;
    while (!done_o && n < 20000) begin
      if (!chip_rst_o) early = 1'b1;
      @(negedge clk); n++;
    end
    chk(done_o == 1'b1, "R10 done seen", 32'(done_o), 1);
    chk(early == 1'b0, "R2 held until done", 32'(early), 0);
    chk(chip_rst_o == 1'b0, "R10 reset released with done", 32'(chip_rst_o), 0);
    chk(pins_oe == 3'b000, "R11 pins released", 32'(pins_oe), 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 single pulse", 32'(done_o), 0);
    chk(n_frames == (exp_ld ? NW : 1), exp_ld ? "R7 frame count" : "R8 stop after signature",
        32'(n_frames), exp_ld ? 32'(NW) : 1);
    chk(frame_err == 0, "R4 frame command/address", 32'(frame_err), 0);
    chk(period_err == 0, "R6 serial clock period", 32'(period_err), 0);
    chk(gap_err == 0, "R7 gap between frames", 32'(gap_err), 0);
    for (int k = 0; k < 16; k++) begin
      cfg_addr = 4'(k);
      @(negedge clk);
      if (k >= NW) e = 16'h0000;
      else if (exp_ld) e = img_word(k, sig, base);
      else e = (k == 1) ? {12'h000, st} : 16'h0000;
      chk(cfg_rdata == e, exp_ld ? "R9 R5 R12 loaded word" : "R8 R12 default word",
          32'(cfg_rdata), 32'(e));
    end
    repeat (10) @(negedge clk);
    chk(pins_oe == 3'b000 && pins_out == 3'b000, "R11 pins stay released",
        32'({pins_oe, pins_out}), 0);
  endtask

  initial begin
    rst = 1'b1; strap_drv = 4'h0; cfg_addr = '0; ee_do = 1'b0;
    cur_sig = '0; cur_base = '0; cmd_acc = '0;
    reset_model();
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R10 no pulse in reset", 32'(done_o), 0);
    for (int v = 0; v < NV; v++)
      run_load(VEC[v][35:32], VEC[v][31:16], VEC[v][15:0], VEC[v][36]);

    // R13: reset arriving mid-load
    rst = 1'b1; strap_drv = 4'h6; cur_sig = 16'h55AA; cur_base = 16'h4444;
    repeat (4) @(negedge clk);
    reset_model();
    rst = 1'b0;
    for (int n = 0; n < 5000 && n_frames < 3; n++) @(negedge clk);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(pins_oe == 3'b000, "R13 pins released after abort", 32'(pins_oe), 0);
    chk(chip_rst_o == 1'b1, "R13 chip held in reset", 32'(chip_rst_o), 1);
    run_load(4'h9, 16'h1234, 16'h4444, 1'b0);
    cfg_addr = 4'd2;
    @(negedge clk);
    chk(cfg_rdata == 16'h0000, "R13 aborted words discarded", 32'(cfg_rdata), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule